// File: doc/BRIEF.md
# Bus Master Privilege Control Unit

This block holds the access attributes that a peripheral bridge applies to each bus master. A single 32-bit control word holds one 4-bit attribute nibble per master. Each nibble says whether that master's reads are trusted, whether its writes are trusted, whether its accesses keep their privilege, and whether its writes may be posted into a write buffer. The bridge asks the block about every passing transaction on a combinational check port. The port takes a master ID, a direction and a supervisor flag. It answers with an allow bit, a bufferable bit and the effective privilege level.

The control word can be changed only through a guarded configuration port, and the guard uses the word itself. A configuration access succeeds only when it is in supervisor mode, is a full 32-bit access at a word-aligned address that hits the register offset, and comes from a master that the current word trusts for that direction. Any other access gets an error response and leaves the word as it was.

The configuration port is a request/response stream. A request is taken when `cfg_req_valid` and `cfg_req_ready` are both high on a rising clock edge. A response is offered one cycle later and holds all of its fields until `cfg_rsp_ready` is high. `cfg_req_ready` is low only while an offered response is being held back, so a new request is never taken before the previous response has gone. The check port has no handshake.

Top module: `mpriv_ctrl`

## Requirements
- R1: After reset every master nibble is binary 0111, so the control word reads 0x77770000.
- R2: Master m owns control-word bits [31-4m : 28-4m]. Inside a nibble, from most to least significant bit, the fields are write-buffer enable, read trust, write trust and privilege level.
- R3: A configuration write takes effect only when all of these hold: `cfg_req_super`=1, the issuing master's write-trust bit is 1, `cfg_req_size`=2'b10 (codes: 00 byte, 01 halfword, 10 word, 11 reserved), `cfg_req_addr[1:0]`=0, and the upper address bits equal the register offset (0). Any other write gets `cfg_rsp_err`=1 and leaves the word unchanged.
- R4: A configuration read follows the same conditions, with the read-trust bit in place of the write-trust bit. A read that passes returns the control word. A read that fails returns `cfg_rsp_err`=1 and `cfg_rsp_rdata`=0. A write response always carries rdata 0.
- R5: Control-word bits [15:0] always read as 0, and values written to them are ignored.
- R6: `chk_allow` equals the read-trust bit (`chk_write`=0) or the write-trust bit (`chk_write`=1) of master `chk_master`.
- R7: `chk_buffer` is 1 only for a write (`chk_write`=1) from a master whose write-buffer bit is 1. Otherwise it is 0.
- R8: `chk_priv` equals `chk_super` AND the privilege-level bit of master `chk_master`. A 0 means the access is treated as user mode.
- R9: The check outputs are combinational from the stored word. During the cycle in which a configuration write is accepted, they still reflect the old word, and they change after that clock edge.
- R10: A response appears one cycle after its request is accepted. It holds `cfg_rsp_err` and `cfg_rsp_rdata` stable until `cfg_rsp_ready` is 1. `cfg_req_ready` equals NOT `cfg_rsp_valid` OR `cfg_rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_req_valid | input | 1 | Configuration request offered |
| cfg_req_ready | output | 1 | Request can be taken this cycle |
| cfg_req_master | input | MID_W (2) | ID of the master issuing the configuration access |
| cfg_req_super | input | 1 | Issuing master is in supervisor mode |
| cfg_req_write | input | 1 | 1 for write, 0 for read |
| cfg_req_size | input | 2 | Access size code (00 byte, 01 half, 10 word) |
| cfg_req_addr | input | ADDR_W (8) | Byte address within the block |
| cfg_req_wdata | input | REG_W (32) | Write data |
| cfg_rsp_valid | output | 1 | Response offered |
| cfg_rsp_ready | input | 1 | Response consumer ready |
| cfg_rsp_err | output | 1 | Access was rejected |
| cfg_rsp_rdata | output | REG_W (32) | Read data, 0 on error or write |
| chk_master | input | MID_W (2) | Master ID of the transaction under check |
| chk_write | input | 1 | Transaction direction, 1 for write |
| chk_super | input | 1 | Transaction supervisor flag |
| chk_allow | output | 1 | Transaction is trusted for its direction |
| chk_buffer | output | 1 | Write may be buffered |
| chk_priv | output | 1 | Effective privilege (1 supervisor, 0 user) |

## Verification
The check outputs are combinational. The bench drives the check inputs in the low half of the clock and samples one time step later, in the same cycle. A configuration response is registered once and becomes valid at the clock edge that accepts the request. The bench drops the request just after that edge and samples the response at the following falling edge. A change to the control word reaches the check outputs only after the accepting edge. The same-cycle test therefore samples once before that edge, where it expects the old attributes, and once at the next falling edge, where it expects the new ones. Under back-pressure, the response fields and the low `cfg_req_ready` are sampled at several falling edges in a row.

// File: rtl/mpriv_pkg.sv
package mpriv_pkg;

  // Width of one master's attribute nibble
  localparam int NIB_W = 4;

  // Bit positions inside a nibble (behavioural: bridge decodes these)
  localparam int BIT_BW = 3;  // write-buffer enable
  localparam int BIT_TR = 2;  // read trust
  localparam int BIT_TW = 1;  // write trust
  localparam int BIT_PL = 0;  // privilege level

  // Per-master reset attributes: not bufferable, trusted both ways, privileged
  localparam logic [NIB_W-1:0] RST_NIB = 4'b0111;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/mpriv_sel.sv
// Picks one bit of a per-master vector by master ID; IDs past the last
// master select a zero.
module mpriv_sel #(
  parameter int N_MST = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_MST-1:0] vec_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  localparam int SPAN = 1 << IDX_W;

  logic [SPAN-1:0] padded;

  for (genvar i = 0; i < SPAN; i++) begin : g_pad
    if (i < N_MST) begin : g_live
      assign padded[i] = vec_i[i];
    end else begin : g_void
      assign padded[i] = 1'b0;
    end
  end

  assign bit_o = padded[idx_i];
endmodule

// File: rtl/mpriv_regfile.sv
module mpriv_regfile
  import mpriv_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int REG_W = 32,
  localparam int USED = N_MST * NIB_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [USED-1:0]             wr_fields_i,
  output logic [REG_W-1:0]            word_o,
  output logic [NIB_W-1:0][N_MST-1:0] attr_cols_o
);

  logic [USED-1:0] fields_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= {N_MST{RST_NIB}};
    end else if (wr_en_i) begin
      fields_q <= wr_fields_i;
    end
  end

  // Master 0 lives in the top nibble, later masters below it
  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    localparam int BASE = USED - (m + 1) * NIB_W;
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
      assign attr_cols_o[b][m] = fields_q[BASE + b];
    end
  end

  if (REG_W > USED) begin : g_pad_low
    assign word_o = {fields_q, {(REG_W - USED){1'b0}}};
  end else begin : g_full
    assign word_o = fields_q;
  end
endmodule

// File: rtl/mpriv_qual.sv
// Decides whether a configuration access may touch the control word.
module mpriv_qual
  import mpriv_pkg::*;
#(
  parameter int N_MST      = 4,
  parameter int MID_W      = 2,
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 0
) (
  input  logic [MID_W-1:0]  master_i,
  input  logic              super_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_MST-1:0]  trust_rd_i,
  input  logic [N_MST-1:0]  trust_wr_i,
  output logic              ok_o
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic rd_trusted, wr_trusted, dir_trusted;
  logic aligned, hit, full_word;

  mpriv_sel #(.N_MST(N_MST), .IDX_W(MID_W)) u_sel_rd (
    .vec_i(trust_rd_i), .idx_i(master_i), .bit_o(rd_trusted)
  );

  mpriv_sel #(.N_MST(N_MST), .IDX_W(MID_W)) u_sel_wr (
    .vec_i(trust_wr_i), .idx_i(master_i), .bit_o(wr_trusted)
  );

  always_comb begin
    dir_trusted = write_i ? wr_trusted : rd_trusted;
    aligned     = (addr_i[1:0] == 2'b00);
    hit         = (addr_i[ADDR_W-1:2] == OFFS[ADDR_W-1:2]);
    full_word   = (acc_size_e'(size_i) == SZ_WORD);
    ok_o        = super_i && dir_trusted && aligned && hit && full_word;
  end
endmodule

// File: rtl/mpriv_lookup.sv
// Per-transaction attribute lookup from the stored control word.
module mpriv_lookup
  import mpriv_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int MID_W = 2
) (
  input  logic [NIB_W-1:0][N_MST-1:0] attr_cols_i,
  input  logic [MID_W-1:0]            master_i,
  input  logic                        write_i,
  input  logic                        super_i,
  output logic                        allow_o,
  output logic                        buffer_o,
  output logic                        priv_o
);
  logic [NIB_W-1:0] attr;

  for (genvar b = 0; b < NIB_W; b++) begin : g_attr
    mpriv_sel #(.N_MST(N_MST), .IDX_W(MID_W)) u_sel (
      .vec_i(attr_cols_i[b]), .idx_i(master_i), .bit_o(attr[b])
    );
  end

  always_comb begin
    allow_o  = write_i ? attr[BIT_TW] : attr[BIT_TR];
    buffer_o = write_i & attr[BIT_BW];
    priv_o   = super_i & attr[BIT_PL];
  end
endmodule

// File: rtl/mpriv_ctrl.sv
module mpriv_ctrl
  import mpriv_pkg::*;
#(
  parameter int N_MST      = 4,
  parameter int REG_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 0,
  parameter int MID_W      = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req_valid,
  output logic              cfg_req_ready,
  input  logic [MID_W-1:0]  cfg_req_master,
  input  logic              cfg_req_super,
  input  logic              cfg_req_write,
  input  logic [1:0]        cfg_req_size,
  input  logic [ADDR_W-1:0] cfg_req_addr,
  input  logic [REG_W-1:0]  cfg_req_wdata,
  output logic              cfg_rsp_valid,
  input  logic              cfg_rsp_ready,
  output logic              cfg_rsp_err,
  output logic [REG_W-1:0]  cfg_rsp_rdata,
  input  logic [MID_W-1:0]  chk_master,
  input  logic              chk_write,
  input  logic              chk_super,
  output logic              chk_allow,
  output logic              chk_buffer,
  output logic              chk_priv
);
  localparam int USED = N_MST * NIB_W;

  logic [REG_W-1:0]            ctrl_word;
  logic [NIB_W-1:0][N_MST-1:0] attr_cols;
  logic                        accept, access_ok, wr_en;
  logic                        rsp_valid_q, rsp_err_q;
  logic [REG_W-1:0]            rsp_rdata_q;

  if (REG_W > USED) begin : g_low_unused
    logic wdata_low_unused;
    assign wdata_low_unused = ^cfg_req_wdata[REG_W-USED-1:0];
  end

  assign cfg_req_ready = !rsp_valid_q || cfg_rsp_ready;
  assign accept        = cfg_req_valid && cfg_req_ready;
  assign wr_en         = accept && cfg_req_write && access_ok;

  mpriv_qual #(
    .N_MST(N_MST), .MID_W(MID_W), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
  ) u_qual (
    .master_i   (cfg_req_master),
    .super_i    (cfg_req_super),
    .write_i    (cfg_req_write),
    .size_i     (cfg_req_size),
    .addr_i     (cfg_req_addr),
    .trust_rd_i (attr_cols[BIT_TR]),
    .trust_wr_i (attr_cols[BIT_TW]),
    .ok_o       (access_ok)
  );

  mpriv_regfile #(.N_MST(N_MST), .REG_W(REG_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_fields_i (cfg_req_wdata[REG_W-1 -: USED]),
    .word_o      (ctrl_word),
    .attr_cols_o (attr_cols)
  );

  mpriv_lookup #(.N_MST(N_MST), .MID_W(MID_W)) u_look (
    .attr_cols_i (attr_cols),
    .master_i    (chk_master),
    .write_i     (chk_write),
    .super_i     (chk_super),
    .allow_o     (chk_allow),
    .buffer_o    (chk_buffer),
    .priv_o      (chk_priv)
  );

  // Response stage: one register, held under back-pressure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= !access_ok;
      rsp_rdata_q <= (access_ok && !cfg_req_write) ? ctrl_word : '0;
    end else if (cfg_rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign cfg_rsp_valid = rsp_valid_q;
  assign cfg_rsp_err   = rsp_err_q;
  assign cfg_rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/mpriv_ctrl_chk.sv
module mpriv_ctrl_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_req_valid,
  input logic             cfg_req_ready,
  input logic             cfg_req_super,
  input logic             cfg_req_write,
  input logic             cfg_rsp_valid,
  input logic             cfg_rsp_ready,
  input logic             cfg_rsp_err,
  input logic [REG_W-1:0] cfg_rsp_rdata,
  input logic             chk_write,
  input logic             chk_super,
  input logic             chk_buffer,
  input logic             chk_priv,
  input logic [REG_W-1:0] ctrl_word
);
  logic taken;
  assign taken = cfg_req_valid && cfg_req_ready;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid && !cfg_rsp_ready |=>
      cfg_rsp_valid && $stable(cfg_rsp_err) && $stable(cfg_rsp_rdata));

  // R10
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> cfg_rsp_valid);

  // R3
  user_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cfg_req_write && !cfg_req_super |=> cfg_rsp_err && $stable(ctrl_word));

  // R3
  word_changes_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken && cfg_req_write) |=> $stable(ctrl_word));

  // R4
  err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid && cfg_rsp_err |-> cfg_rsp_rdata == '0);

  // R5
  low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid |-> cfg_rsp_rdata[15:0] == 16'h0000);

  // R7
  buffer_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_buffer |-> chk_write);

  // R8
  priv_needs_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_priv |-> chk_super);
endmodule

bind mpriv_ctrl mpriv_ctrl_chk #(.REG_W(REG_W)) u_mpriv_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_super (cfg_req_super),
  .cfg_req_write (cfg_req_write),
  .cfg_rsp_valid (cfg_rsp_valid),
  .cfg_rsp_ready (cfg_rsp_ready),
  .cfg_rsp_err   (cfg_rsp_err),
  .cfg_rsp_rdata (cfg_rsp_rdata),
  .chk_write     (chk_write),
  .chk_super     (chk_super),
  .chk_buffer    (chk_buffer),
  .chk_priv      (chk_priv),
  .ctrl_word     (ctrl_word)
);

// File: tb/test_mpriv_ctrl.sv
`timescale 1ns/1ps
module test_mpriv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req_valid = 1'b0;
  logic        cfg_req_ready;
  logic [1:0]  cfg_req_master = '0;
  logic        cfg_req_super = 1'b0;
  logic        cfg_req_write = 1'b0;
  logic [1:0]  cfg_req_size = 2'b10;
  logic [7:0]  cfg_req_addr = '0;
  logic [31:0] cfg_req_wdata = '0;
  logic        cfg_rsp_valid;
  logic        cfg_rsp_ready = 1'b1;
  logic        cfg_rsp_err;
  logic [31:0] cfg_rsp_rdata;
  logic [1:0]  chk_master = '0;
  logic        chk_write = 1'b0;
  logic        chk_super = 1'b0;
  logic        chk_allow, chk_buffer, chk_priv;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  mpriv_ctrl i_mpriv_ctrl (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One configuration access with the consumer ready; returns the response
  task automatic cfg_access(input logic [1:0] m, input logic sup, input logic wr,
                            input logic [1:0] sz, input logic [7:0] ad,
                            input logic [31:0] wd, output logic e, output logic [31:0] rd);
    @(negedge clk);
    cfg_req_master = m; cfg_req_super = sup; cfg_req_write = wr;
    cfg_req_size = sz; cfg_req_addr = ad; cfg_req_wdata = wd;
    cfg_req_valid = 1'b1;
    @(posedge clk);
    #1 cfg_req_valid = 1'b0;
    @(negedge clk);
    check("R10 response valid", {31'b0, cfg_rsp_valid}, 32'd1);
    e = cfg_rsp_err;
    rd = cfg_rsp_rdata;
  endtask

  task automatic write_ok(input logic [31:0] wd);
    logic e; logic [31:0] rd;
    cfg_access(2'd0, 1'b1, 1'b1, 2'b10, 8'h00, wd, e, rd);
    check("R3 qualified write err", {31'b0, e}, 32'd0);
  endtask

  task automatic read_word(input string tag, input logic [31:0] exp);
    logic e; logic [31:0] rd;
    cfg_access(2'd0, 1'b1, 1'b0, 2'b10, 8'h00, 32'h0, e, rd);
    check({tag, " read err"}, {31'b0, e}, 32'd0);
    check({tag, " read data"}, rd, exp);
  endtask

  task automatic look(input string tag, input logic [1:0] m, input logic wr, input logic sup,
                      input logic a, input logic b, input logic p);
    @(negedge clk);
    chk_master = m; chk_write = wr; chk_super = sup;
    #1;
    check({tag, " R6 allow"},  {31'b0, chk_allow},  {31'b0, a});
    check({tag, " R7 buffer"}, {31'b0, chk_buffer}, {31'b0, b});
    check({tag, " R8 priv"},   {31'b0, chk_priv},   {31'b0, p});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 reset rsp_valid", {31'b0, cfg_rsp_valid}, 32'd0);
    check("R10 reset req_ready", {31'b0, cfg_req_ready}, 32'd1);
    look("R1 reset m0 rd", 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    look("R1 reset m3 wr", 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    read_word("R1 reset value", 32'h7777_0000);
  endtask

  task automatic t_low_half;
    write_ok(32'h7777_FFFF);
    read_word("R5 low half", 32'h7777_0000);
  endtask

  task automatic t_reject;
    logic e; logic [31:0] rd;
    cfg_access(2'd0, 1'b1, 1'b1, 2'b10, 8'h01, 32'h0, e, rd);
    check("R3 unaligned write err", {31'b0, e}, 32'd1);
    cfg_access(2'd0, 1'b1, 1'b1, 2'b00, 8'h00, 32'h0, e, rd);
    check("R3 byte write err", {31'b0, e}, 32'd1);
    cfg_access(2'd0, 1'b1, 1'b1, 2'b01, 8'h00, 32'h0, e, rd);
    check("R3 half write err", {31'b0, e}, 32'd1);
    cfg_access(2'd0, 1'b0, 1'b1, 2'b10, 8'h00, 32'h0, e, rd);
    check("R3 user write err", {31'b0, e}, 32'd1);
    cfg_access(2'd0, 1'b1, 1'b1, 2'b10, 8'h04, 32'h0, e, rd);
    check("R3 off-register write err", {31'b0, e}, 32'd1);
    read_word("R3 unchanged after rejects", 32'h7777_0000);
    cfg_access(2'd0, 1'b1, 1'b0, 2'b10, 8'h02, 32'h0, e, rd);
    check("R4 unaligned read err", {31'b0, e}, 32'd1);
    check("R4 unaligned read data", rd, 32'h0);
    cfg_access(2'd0, 1'b0, 1'b0, 2'b10, 8'h00, 32'h0, e, rd);
    check("R4 user read err", {31'b0, e}, 32'd1);
    cfg_access(2'd1, 1'b1, 1'b0, 2'b11, 8'h00, 32'h0, e, rd);
    check("R4 reserved size read err", {31'b0, e}, 32'd1);
    // master 2 nibble 0100: read trusted, write untrusted
    write_ok(32'h7747_0000);
    cfg_access(2'd2, 1'b1, 1'b1, 2'b10, 8'h00, 32'h0, e, rd);
    check("R3 untrusted write err", {31'b0, e}, 32'd1);
    cfg_access(2'd2, 1'b1, 1'b0, 2'b10, 8'h00, 32'h0, e, rd);
    check("R4 read-trusted master err", {31'b0, e}, 32'd0);
    check("R4 read-trusted master data", rd, 32'h7747_0000);
    // master 3 nibble 0000: untrusted for reads
    write_ok(32'h7740_0000);
    cfg_access(2'd3, 1'b1, 1'b0, 2'b10, 8'h00, 32'h0, e, rd);
    check("R4 untrusted read err", {31'b0, e}, 32'd1);
    check("R4 untrusted read data", rd, 32'h0);
    write_ok(32'h7777_0000);
    read_word("R2 restored", 32'h7777_0000);
  endtask

  task automatic t_lookup;
    // m0=1111 m1=1000 m2=1010 m3=0101
    write_ok(32'hF8A5_0000);
    read_word("R2 reprogram", 32'hF8A5_0000);
    look("R2 m0 wr",      2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    look("R2 m1 rd",      2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R2 m1 wr",      2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    look("R2 m2 rd",      2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R2 m2 wr",      2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    look("R2 m3 rd",      2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    look("R2 m3 wr",      2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    look("R8 m3 user",    2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    look("R8 m0 user wr", 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    write_ok(32'h7777_0000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    chk_master = 2'd1; chk_write = 1'b0; chk_super = 1'b1;
    cfg_req_master = 2'd0; cfg_req_super = 1'b1; cfg_req_write = 1'b1;
    cfg_req_size = 2'b10; cfg_req_addr = 8'h00; cfg_req_wdata = 32'h7077_0000;
    cfg_req_valid = 1'b1;
    #1;
    check("R9 old value during write", {31'b0, chk_allow}, 32'd1);
    @(posedge clk);
    #1 cfg_req_valid = 1'b0;
    @(negedge clk);
    check("R9 new value after edge", {31'b0, chk_allow}, 32'd0);
    write_ok(32'h7777_0000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    cfg_rsp_ready = 1'b0;
    cfg_req_master = 2'd0; cfg_req_super = 1'b1; cfg_req_write = 1'b0;
    cfg_req_size = 2'b10; cfg_req_addr = 8'h00;
    cfg_req_valid = 1'b1;
    @(posedge clk);
    #1 cfg_req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 held valid", {31'b0, cfg_rsp_valid}, 32'd1);
      check("R10 held ready low", {31'b0, cfg_req_ready}, 32'd0);
      check("R10 held data", cfg_rsp_rdata, 32'h7777_0000);
    end
    cfg_rsp_ready = 1'b1;
    #1;
    check("R10 ready follows consumer", {31'b0, cfg_req_ready}, 32'd1);
    @(negedge clk);
    check("R10 response drained", {31'b0, cfg_rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_low_half();
    t_reject();
    t_lookup();
    t_same_cycle();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule